// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block gathers 64 active-low interrupt lines into two 32-bit register words, an upper and a lower one. Each word has an enable (mask) register and a pending register, and the block drives one interrupt output towards the processor. A source's place inside the register words is set by a fixed scrambled map and does not follow from its number. Software finds the source to serve by reading a vector register. It clears latched edge events by writing ones to the pending words.

Each source line passes through a two-flop synchronizer. Internal sources are always sensed as active-low levels. Seven external lines and sixteen port lines can each be switched to falling-edge sensing by a bit in a sense register. Access is through a plain 32-bit register bus: a write strobe, a word address, write data, and combinational read data.

Top module: `irq_ctrl64`

## Requirements
- R1: While `rst_n` is low at a clock edge, both enable words, all pending bits and the sense register return to zero. After reset, `irq_o` is low and the vector reads 0.
- R2: Pending word addresses are 2 (upper) and 3 (lower). In the upper word, source 0 sits at bit 0, sources 1..15 at bit 16-n, and sources 32..47 at bit 63-n. In the lower word, sources 16..18 sit at bit 18-n, sources 19..30 at bit 33-n, source 31 at bit 15, and sources 48..63 at bit n-32. The enable words at addresses 0 (upper) and 1 (lower) use the same bit placement.
- R3: A level-sensed source has its pending bit set while its line is low and cleared while it is high. A write-one-to-clear has no lasting effect on it.
- R4: The sense register is at address 4. External sources 19..25 use sense bit 33-n and port sources 48..63 use sense bit 79-n. A 1 there selects falling-edge sensing, which sets the pending bit once per high-to-low transition and keeps it set after the line rises. All other sense bits read back as 0.
- R5: Writing to a pending word clears every edge-latched pending bit whose written data bit is 1. A written 0 leaves the bit unchanged.
- R6: An enable bit of 1 lets its source through. `irq_o` is high exactly when some source is both pending and enabled.
- R7: The vector register is at address 5. Bits 31:26 hold the lowest-numbered source in 1..63 that is pending and enabled, or 0 when there is none. Bits 25:0 read 0.
- R8: Reading any register changes no state. Writes to address 5 are ignored. Addresses 6 and 7 read as 0.
- R9: A line change becomes visible in the pending words on the third rising clock edge after it is applied, and not before.
- R10: Source 0 acts as an internal level source that can raise `irq_o`, but the vector never names it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_n | input | 64 | Interrupt lines, active low, bit n is source n |
| wr_en | input | 1 | Register write strobe, taken at the rising edge |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 1 | Interrupt request to the processor, active high |

## Verification
A line change is due in the pending words three rising edges after it is driven. The bench checks each one twice: once after two edges, where the value must still be the old one, and once after the third edge. Enable, sense and write-one-to-clear writes act at the edge that takes the strobe. `irq_o`, the vector and the read data follow combinationally from registered state, so the bench drives every input on the falling edge and samples just after it. Checks made after a wait of four or more cycles are those where only the settled value matters, such as the priority order.

// File: rtl/irq64_pkg.sv
// Package: shared constants and the fixed source-to-bit placement for the
// sixty-four source interrupt controller. Assumes exactly 64 sources.
package irq64_pkg;

    localparam int NUM_SRC = 64;

    // Register word addresses (3-bit word index)
    localparam int A_MASK_HI = 0;
    localparam int A_MASK_LO = 1;
    localparam int A_PEND_HI = 2;
    localparam int A_PEND_LO = 3;
    localparam int A_SENSE   = 4;
    localparam int A_VECTOR  = 5;

    // Source lives in the lower word when bit 4 of its number is set
    function automatic bit src_in_low(input int n);
        return ((n / 16) % 2) == 1;
    endfunction

    // Bit position of a source inside its word (scrambled placement)
    function automatic int src_bit(input int n);
        if (n == 0)       return 0;
        else if (n < 16)  return 16 - n;
        else if (n <= 18) return 18 - n;
        else if (n <= 30) return 33 - n;
        else if (n == 31) return 15;
        else if (n < 48)  return 63 - n;
        else              return n - 32;
    endfunction

    // True for the external and port sources that own a sense bit
    function automatic bit has_sense(input int n);
        return (n >= 19 && n <= 25) || (n >= 48 && n <= 63);
    endfunction

    // Sense register bit owned by a sensed source
    function automatic int sense_bit(input int n);
        if (n >= 19 && n <= 25) return 33 - n;
        else                    return 79 - n;
    endfunction

    // Mask of sense register bits that are implemented
    function automatic logic [31:0] sense_legal();
        logic [31:0] m;
        m = '0;
        for (int n = 0; n < NUM_SRC; n++)
            if (has_sense(n)) m[sense_bit(n)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/irq64_sync.sv
// Module: multi-stage synchronizer for a bus of active-low lines.
// Assumes each bit is an independent asynchronous line; resets to the
// inactive (high) level so no false event follows reset.
module irq64_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_n,
    output logic [WIDTH-1:0] q_n
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the lines through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= d_n;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_n = stage_q[STAGES-1];
endmodule

// File: rtl/irq64_src_cell.sv
// Module: pending state of one source. Level mode mirrors the synced
// active-low line; edge mode latches a high-to-low transition until a
// write-one-to-clear. Assumes line_n is already synchronized.
module irq64_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic line_n,
    input  logic edge_sel,
    input  logic clr,
    output logic pend
);
    logic prev_n;

    // Track previous line level and update the pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_n <= 1'b1;
            pend   <= 1'b0;
        end else begin
            prev_n <= line_n;
            if (edge_sel)
                pend <= (pend & ~clr) | (prev_n & ~line_n);
            else
                pend <= ~line_n;
        end
    end
endmodule

// File: rtl/irq64_prio.sv
// Module: fixed-priority encoder, lowest index wins; index 0 is not a
// request and an all-zero input yields id 0.
module irq64_prio #(
    parameter int N    = 64,
    parameter int ID_W = $clog2(N)
) (
    input  logic [N-1:1]  req,
    output logic [ID_W-1:0] id
);
    // Scan from the top so the lowest requesting index is kept last
    always_comb begin
        id = '0;
        for (int i = N - 1; i >= 1; i--)
            if (req[i]) id = ID_W'(i);
    end
endmodule

// File: rtl/irq_ctrl64.sv
// Module: sixty-four source interrupt controller top. Holds the enable
// and sense registers, builds the scrambled pending/enable words, and
// produces the vector and the interrupt output. Assumes a single-cycle
// register bus with combinational read data.
module irq_ctrl64
    import irq64_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   src_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 irq_o
);
    localparam int ID_W    = $clog2(NUM_SRC);
    localparam int VEC_LSB = DATA_W - ID_W;
    localparam logic [DATA_W-1:0] SENSE_MASK = DATA_W'(sense_legal());

    logic [DATA_W-1:0]  mask_hi_q, mask_lo_q, sense_q;
    logic [DATA_W-1:0]  pend_hi_w, pend_lo_w;
    logic [NUM_SRC-1:0] line_n, pend_src, active, edge_sel;
    logic [ID_W-1:0]    vec_id;

    irq64_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_n  (src_n),
        .q_n  (line_n)
    );

    // Register writes for enable and sense words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_hi_q <= '0;
            mask_lo_q <= '0;
            sense_q   <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_MASK_HI)) mask_hi_q <= wdata;
            if (addr == ADDR_W'(A_MASK_LO)) mask_lo_q <= wdata;
            if (addr == ADDR_W'(A_SENSE))   sense_q   <= wdata & SENSE_MASK;
        end
    end

    for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
        localparam int BIT = src_bit(n);
        localparam bit LOW = src_in_low(n);
        logic clr;

        assign clr = wr_en && wdata[BIT] &&
                     (addr == ADDR_W'(LOW ? A_PEND_LO : A_PEND_HI));

        if (has_sense(n)) begin : g_sensed
            assign edge_sel[n] = sense_q[sense_bit(n)];
        end else begin : g_internal
            assign edge_sel[n] = 1'b0;
        end

        if (LOW) begin : g_low
            assign pend_lo_w[BIT] = pend_src[n];
            assign active[n]      = pend_src[n] & mask_lo_q[BIT];
        end else begin : g_high
            assign pend_hi_w[BIT] = pend_src[n];
            assign active[n]      = pend_src[n] & mask_hi_q[BIT];
        end

        irq64_src_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_n  (line_n[n]),
            .edge_sel(edge_sel[n]),
            .clr     (clr),
            .pend    (pend_src[n])
        );
    end

    irq64_prio #(.N(NUM_SRC), .ID_W(ID_W)) u_prio (
        .req(active[NUM_SRC-1:1]),
        .id (vec_id)
    );

    // Any enabled pending source raises the processor request
    assign irq_o = |active;

    // Read data multiplexer, free of side effects
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(A_MASK_HI): rdata = mask_hi_q;
            ADDR_W'(A_MASK_LO): rdata = mask_lo_q;
            ADDR_W'(A_PEND_HI): rdata = pend_hi_w;
            ADDR_W'(A_PEND_LO): rdata = pend_lo_w;
            ADDR_W'(A_SENSE):   rdata = sense_q;
            ADDR_W'(A_VECTOR):  rdata[DATA_W-1:VEC_LSB] = vec_id;
            default:            rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl64_chk.sv
// Module: assertion checker for irq_ctrl64, attached by bind. Observes
// the enable/sense registers, the per-source pending flags and the
// encoder result.
module irq_ctrl64_chk
    import irq64_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [31:0]        mask_hi_q,
    input logic [31:0]        mask_lo_q,
    input logic [31:0]        sense_q,
    input logic [NUM_SRC-1:0] pend_src,
    input logic [5:0]         vec_id,
    input logic               irq_o
);
    function automatic logic enabled(input logic [5:0] id);
        int n;
        n = int'(id);
        return src_in_low(n) ? mask_lo_q[src_bit(n)] : mask_hi_q[src_bit(n)];
    endfunction

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (mask_hi_q == '0 && mask_lo_q == '0 && pend_src == '0));

    // R7
    vec_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_id != '0) |-> (pend_src[vec_id] && enabled(vec_id)));

    // R6
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == ((vec_id != '0) || (pend_src[0] && mask_hi_q[0])));

    // R4
    sense_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_q & ~sense_legal()) == '0);
endmodule

bind irq_ctrl64 irq_ctrl64_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_hi_q(mask_hi_q),
    .mask_lo_q(mask_lo_q),
    .sense_q  (sense_q),
    .pend_src (pend_src),
    .vec_id   (vec_id),
    .irq_o    (irq_o)
);

// File: tb/irq_ctrl64_tb.sv
// Bench: table walk over the scrambled bit placement, then directed tests.
module irq_ctrl64_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_n = '1;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_ctrl64 u_dut (
        .clk(clk), .rst_n(rst_n), .src_n(src_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    // {source[5:0], word address[2:0], bit[4:0]}
    localparam logic [13:0] VECS [12] = '{
        {6'd1,  3'd2, 5'd15}, {6'd15, 3'd2, 5'd1},  {6'd16, 3'd3, 5'd2},
        {6'd18, 3'd3, 5'd0},  {6'd19, 3'd3, 5'd14}, {6'd30, 3'd3, 5'd3},
        {6'd31, 3'd3, 5'd15}, {6'd32, 3'd2, 5'd31}, {6'd47, 3'd2, 5'd16},
        {6'd48, 3'd3, 5'd16}, {6'd63, 3'd3, 5'd31}, {6'd25, 3'd3, 5'd8}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        addr = 3'(a);
        #1 v = rdata;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(0, v); chk("R1 mask_hi", v, 0);
        rd(1, v); chk("R1 mask_lo", v, 0);
        rd(2, v); chk("R1 pend_hi", v, 0);
        rd(5, v); chk("R1 vector", v, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);

        // R2 / R9 / R3 table walk on level-sensed sources
        for (int i = 0; i < 12; i++) begin
            int s, a, b;
            s = int'(VECS[i][13:8]); a = int'(VECS[i][7:5]); b = int'(VECS[i][4:0]);
            @(negedge clk) src_n[s] = 1'b0;
            repeat (2) @(posedge clk);
            @(negedge clk); rd(a, v); chk("R9 not yet", v, 0);
            @(posedge clk);
            @(negedge clk); rd(a, v); chk("R2 placement", v, 32'd1 << b);
            src_n[s] = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk); rd(a, v); chk("R3 level release", v, 0);
        end

        // R6 masking and irq
        @(negedge clk) src_n[5] = 1'b0;
        settle();
        chk("R6 masked irq", {31'd0, irq_o}, 0);
        wr(0, 32'd1 << 11);
        #1 chk("R6 enabled irq", {31'd0, irq_o}, 1);
        rd(5, v); chk("R7 vector 5", v, 32'd5 << 26);

        // R7 priority order
        wr(0, '1); wr(1, '1);
        src_n[20] = 1'b0; src_n[40] = 1'b0;
        settle();
        rd(5, v); chk("R7 lowest wins", v, 32'd5 << 26);
        src_n[5] = 1'b1;
        settle();
        rd(5, v); chk("R7 next 20", v, 32'd20 << 26);
        wr(1, ~(32'd1 << 13));
        #1 rd(5, v); chk("R7 masked skip", v, 32'd40 << 26);
        src_n[20] = 1'b1; src_n[40] = 1'b1;
        settle();
        rd(5, v); chk("R7 none", v, 0);
        chk("R6 idle irq", {31'd0, irq_o}, 0);

        // R4 sense register legal bits
        wr(4, '1);
        rd(4, v); chk("R4 sense bits", v, 32'hFFFF7F00);
        wr(4, (32'd1 << 11) | (32'd1 << 29));

        // R4 / R5 falling edge on source 22 (lower bit 11)
        src_n[22] = 1'b0;
        repeat (2) @(negedge clk);
        src_n[22] = 1'b1;
        settle();
        rd(3, v); chk("R4 edge latched", v, 32'd1 << 11);
        rd(5, v); chk("R7 vector 22", v, 32'd22 << 26);
        wr(3, 32'd0);
        rd(3, v); chk("R5 zero keeps", v, 32'd1 << 11);
        wr(3, 32'd1 << 11);
        rd(3, v); chk("R5 one clears", v, 0);

        // R4 port source 50 held low: one event only
        src_n[50] = 1'b0;
        settle();
        rd(3, v); chk("R4 port edge", v, 32'd1 << 18);
        wr(3, 32'd1 << 18);
        settle();
        rd(3, v); chk("R4 no retrigger", v, 0);
        src_n[50] = 1'b1;
        settle();

        // R3 level source ignores write-one-to-clear
        src_n[20] = 1'b0;
        settle();
        wr(3, 32'd1 << 13);
        @(negedge clk); rd(3, v); chk("R3 level w1c", v, 32'd1 << 13);
        src_n[20] = 1'b1;
        settle();

        // R8 reads harmless, vector writes ignored
        src_n[40] = 1'b0;
        settle();
        rd(5, v); @(negedge clk); rd(5, v2);
        chk("R8 vector reread", v2, v);
        chk("R8 vector value", v, 32'd40 << 26);
        wr(5, 32'd0);
        rd(2, v); chk("R8 vector write", v, 32'd1 << 23);
        rd(6, v); chk("R8 unused addr", v, 0);
        src_n[40] = 1'b1;
        settle();

        // R10 source 0
        src_n[0] = 1'b0;
        settle();
        rd(2, v); chk("R10 pend bit0", v, 32'd1);
        rd(5, v); chk("R10 vector", v, 0);
        chk("R10 irq", {31'd0, irq_o}, 1);

        // R1 reset mid-run
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        #1 rd(0, v); chk("R1 mask after reset", v, 0);
        rd(4, v); chk("R1 sense after reset", v, 0);
        chk("R1 irq after reset", {31'd0, irq_o}, 0);
        src_n[0] = 1'b1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule